// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock for an I2C master. A prescaler first divides the system clock into a slower module tick. A phase counter then times the low half and the high half of each SCL period in those ticks. Each half lasts its programmed count plus a fixed extra number of ticks. That extra amount depends on the prescaler: it is 7 when the prescaler is zero and 5 otherwise. So one SCL period is (P+1)·((L+d)+(H+d)) system clocks.

Software programs the prescaler, the low count, the high count and a control word through a simple write port. A run bit and an enable bit both have to be set before the clock toggles. While either is clear, SCL is released high. The bit engine follows the waveform through two one-cycle strobes. One marks the first cycle of each low phase and the other marks the first cycle of each high phase. Register writes go to shadow copies. These are loaded into the working set only when a low phase starts, so a period in flight is never shortened or stretched.

Top module: `scl_clock_gen`

## Requirements
- R1: After reset, scl_o is 1 and both strobes are 0. All three count registers read as zero, so enabling without any write gives low and high phases of 7 clocks each.
- R2: While the run bit (control word bit 0, register select 3) is 0, scl_o stays 1 and no strobe is raised.
- R3: While the enable bit (control word bit 1) is 0, scl_o stays 1 and no strobe is raised. Clearing it while the clock runs releases scl_o high on the next clock edge.
- R4: With prescaler P = 0, a low phase lasts L+7 clocks and a high phase lasts H+7 clocks.
- R5: With P > 0, a low phase lasts (P+1)·(L+5) clocks and a high phase lasts (P+1)·(H+5) clocks.
- R6: fall_stb is a one-cycle pulse in the first cycle that scl_o is low. rise_stb is a one-cycle pulse in the first cycle that scl_o is high again.
- R7: When run and enable are both set, scl_o goes low with fall_stb on the clock edge after the one that stores the control write.
- R8: Register select 0 writes the prescaler, 1 the low count and 2 the high count, each 16 bits. A write during a period takes effect only from the next low-phase start.
- R9: fall_stb and rise_stb are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 prescaler, 1 low count, 2 high count, 3 control |
| cfg_wdata | input | 16 | Write data; for control, bit 0 is run and bit 1 is enable |
| scl_o | output | 1 | SCL drive level (1 = released) |
| fall_stb | output | 1 | Pulse in the first cycle of a low phase |
| rise_stb | output | 1 | Pulse in the first cycle of a high phase |

## Verification
The properties assume the control bits change only through the write port. From that, the gate signal that combines run and enable is taken to move at most once per write. The phase properties also rely on every phase lasting at least five clocks, which the extra delay guarantees for every count. The stimulus always writes on the falling clock edge and holds the write strobe for one cycle only. Mid-period updates land inside a phase already being timed, so each shadow load is checked against the period before and after it.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        SEL_PSC  = 2'd0,
        SEL_LOW  = 2'd1,
        SEL_HIGH = 2'd2,
        SEL_CTRL = 2'd3
    } cfg_sel_e;

    localparam int unsigned CTRL_RUN_BIT = 0;
    localparam int unsigned CTRL_EN_BIT  = 1;

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
    import scl_gen_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] psc,
    output logic [DW-1:0] low_cnt,
    output logic [DW-1:0] high_cnt,
    output logic          run,
    output logic          en
);

    typedef struct packed {
        logic [DW-1:0] psc;
        logic [DW-1:0] low_cnt;
        logic [DW-1:0] high_cnt;
        logic          run;
        logic          en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            unique case (cfg_sel_e'(sel))
                SEL_PSC:  r_d.psc      = wdata;
                SEL_LOW:  r_d.low_cnt  = wdata;
                SEL_HIGH: r_d.high_cnt = wdata;
                SEL_CTRL: begin
                    r_d.run = wdata[CTRL_RUN_BIT];
                    r_d.en  = wdata[CTRL_EN_BIT];
                end
                default: r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign psc      = r_q.psc;
    assign low_cnt  = r_q.low_cnt;
    assign high_cnt = r_q.high_cnt;
    assign run      = r_q.run;
    assign en       = r_q.en;

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [DW-1:0] limit,
    output logic          tick
);

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = !clear && (cnt_q == limit);
        if (clear || tick) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
    parameter int unsigned DW      = 16,
    parameter int unsigned D_DIRECT = 7,
    parameter int unsigned D_DIV    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          tick,
    input  logic [DW-1:0] sh_psc,
    input  logic [DW-1:0] sh_low,
    input  logic [DW-1:0] sh_high,
    output logic          scl,
    output logic          fall_stb,
    output logic          rise_stb,
    output logic          running,
    output logic [DW-1:0] act_psc
);

    localparam int unsigned PW = DW + 1;

    typedef struct packed {
        logic          scl;
        logic          fall;
        logic          rise;
        logic          running;
        logic [DW-1:0] a_psc;
        logic [DW-1:0] a_low;
        logic [DW-1:0] a_high;
        logic [PW-1:0] cnt;
    } state_t;

    state_t s_d, s_q;
    logic [PW-1:0] extra;
    logic [PW-1:0] len;

    always_comb begin
        s_d      = s_q;
        s_d.fall = 1'b0;
        s_d.rise = 1'b0;
        extra    = (s_q.a_psc == '0) ? PW'(D_DIRECT) : PW'(D_DIV);
        len      = (s_q.scl ? {1'b0, s_q.a_high} : {1'b0, s_q.a_low}) + extra;
        if (!go) begin
            s_d.scl     = 1'b1;
            s_d.running = 1'b0;
            s_d.cnt     = '0;
        end else if (!s_q.running) begin
            s_d.running = 1'b1;
            s_d.scl     = 1'b0;
            s_d.fall    = 1'b1;
            s_d.cnt     = '0;
            s_d.a_psc   = sh_psc;
            s_d.a_low   = sh_low;
            s_d.a_high  = sh_high;
        end else if (tick) begin
            if (s_q.cnt == len - 1'b1) begin
                s_d.cnt = '0;
                if (s_q.scl) begin
                    s_d.scl    = 1'b0;
                    s_d.fall   = 1'b1;
                    s_d.a_psc  = sh_psc;
                    s_d.a_low  = sh_low;
                    s_d.a_high = sh_high;
                end else begin
                    s_d.scl  = 1'b1;
                    s_d.rise = 1'b1;
                end
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.scl <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl      = s_q.scl;
    assign fall_stb = s_q.fall;
    assign rise_stb = s_q.rise;
    assign running  = s_q.running;
    assign act_psc  = s_q.a_psc;

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
    parameter int unsigned DW       = 16,
    parameter int unsigned D_DIRECT = 7,
    parameter int unsigned D_DIV    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    output logic          scl_o,
    output logic          fall_stb,
    output logic          rise_stb
);

    logic [DW-1:0] sh_psc, sh_low, sh_high, act_psc;
    logic          cfg_run, cfg_en, ctrl_go;
    logic          tick, running;

    scl_cfg_regs #(.DW(DW)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .psc      (sh_psc),
        .low_cnt  (sh_low),
        .high_cnt (sh_high),
        .run      (cfg_run),
        .en       (cfg_en)
    );

    assign ctrl_go = cfg_run && cfg_en;

    scl_prescaler #(.DW(DW)) psc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!running),
        .limit (act_psc),
        .tick  (tick)
    );

    scl_phase_gen #(.DW(DW), .D_DIRECT(D_DIRECT), .D_DIV(D_DIV)) phase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (ctrl_go),
        .tick     (tick),
        .sh_psc   (sh_psc),
        .sh_low   (sh_low),
        .sh_high  (sh_high),
        .scl      (scl_o),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb),
        .running  (running),
        .act_psc  (act_psc)
    );

endmodule

// File: rtl/scl_gen_chk.sv
module scl_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic go,
    input logic scl_o,
    input logic fall_stb,
    input logic rise_stb
);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_stb && rise_stb));

    // R6
    fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> $fell(scl_o));

    // R6
    rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> $rose(scl_o));

    // R2
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (scl_o && !fall_stb && !rise_stb));

    // R4
    low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_stb && go) |=> !scl_o);

    // R7
    start_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go) |=> fall_stb);

endmodule

bind scl_clock_gen scl_gen_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (ctrl_go),
    .scl_o    (scl_o),
    .fall_stb (fall_stb),
    .rise_stb (rise_stb)
);

// File: tb/scl_clock_gen_tb_top.sv
module scl_clock_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = '0;
    logic        scl_o, fall_stb, rise_stb;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // psc, low, high, expected low clocks, expected high clocks
    localparam int VEC [5][5] = '{
        '{0, 0,  0,  7,   7},
        '{0, 3,  10, 10,  17},
        '{1, 0,  0,  10,  10},
        '{2, 4,  1,  27,  18},
        '{4, 10, 20, 75,  125}
    };

    scl_clock_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .scl_o     (scl_o),
        .fall_stb  (fall_stb),
        .rise_stb  (rise_stb)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: act cycles=%0d exp below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] v);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic meas_low(output int n);
        n = 1;
        repeat (3000) begin
            @(negedge clk);
            if (scl_o) break;
            n++;
        end
    endtask

    task automatic meas_high(output int n);
        n = 1;
        repeat (3000) begin
            @(negedge clk);
            if (!scl_o) break;
            n++;
        end
    endtask

    task automatic wait_rise();
        repeat (3000) begin
            @(negedge clk);
            if (rise_stb) break;
        end
    endtask

    task automatic wait_fall();
        repeat (3000) begin
            @(negedge clk);
            if (fall_stb) break;
        end
    endtask

    task automatic idle_for(input int n, input string req);
        int bad = 0;
        repeat (n) begin
            @(negedge clk);
            if (!scl_o || fall_stb || rise_stb) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        int lo, hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(scl_o && !fall_stb && !rise_stb, "R1", {scl_o, fall_stb, rise_stb}, 3'b100);

        // R2 run bit clear holds idle
        wr(2'd3, 16'h0002);
        idle_for(40, "R2");
        // R3 enable clear holds idle
        wr(2'd3, 16'h0001);
        idle_for(40, "R3");

        // R1 default counts after reset, R7 start timing
        wr(2'd3, 16'h0003);
        @(negedge clk);
        chk(!scl_o && fall_stb, "R7", {scl_o, fall_stb}, 2'b01);
        meas_low(lo);
        chk(lo == 7, "R1 low", lo, 7);
        chk(rise_stb, "R6 rise", rise_stb, 1);
        meas_high(hi);
        chk(hi == 7, "R1 high", hi, 7);

        // table walk: R4 / R5 / R6 / R7
        for (int i = 0; i < 5; i++) begin
            wr(2'd3, 16'h0000);
            wr(2'd0, 16'(VEC[i][0]));
            wr(2'd1, 16'(VEC[i][1]));
            wr(2'd2, 16'(VEC[i][2]));
            wr(2'd3, 16'h0003);
            @(negedge clk);
            chk(fall_stb && !scl_o, "R7", {scl_o, fall_stb}, 2'b01);
            meas_low(lo);
            chk(lo == VEC[i][3], (VEC[i][0] == 0) ? "R4 low" : "R5 low", lo, VEC[i][3]);
            chk(rise_stb && !fall_stb, "R6", {rise_stb, fall_stb}, 2'b10);
            meas_high(hi);
            chk(hi == VEC[i][4], (VEC[i][0] == 0) ? "R4 high" : "R5 high", hi, VEC[i][4]);
        end

        // R8 mid-period update of the high count
        wr(2'd3, 16'h0000);
        wr(2'd0, 16'd0);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd0);
        wr(2'd3, 16'h0003);
        @(negedge clk);
        wr(2'd2, 16'd13);
        wait_rise();
        meas_high(hi);
        chk(hi == 7, "R8 old high kept", hi, 7);
        meas_low(lo);
        chk(lo == 7, "R8 low", lo, 7);
        meas_high(hi);
        chk(hi == 20, "R8 new high", hi, 20);

        // R8 prescaler change applied at next low start
        wait_rise();
        wr(2'd0, 16'd1);
        wait_fall();
        meas_low(lo);
        chk(lo == 10, "R8 new psc low", lo, 10);
        meas_high(hi);
        chk(hi == 36, "R8 new psc high", hi, 36);

        // R3 disable mid-period
        wr(2'd3, 16'h0001);
        @(negedge clk);
        chk(scl_o == 1'b1, "R3 release", scl_o, 1);
        idle_for(40, "R3 idle");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule